// File: doc/BRIEF.md
# Instruction Immediate Assembler

This block rebuilds the sign-extended immediate operand of a 32-bit RISC-V base-integer instruction word. The immediate bits sit in different places in the word depending on the instruction's format. A format-select code, which a separate control decoder provides, tells the block which layout to gather. The block reads the instruction bits, collects them in the right order, inserts the implicit zero bits and fills the upper bits with the instruction's sign bit.

The assembly logic is purely combinational. The top level adds one register stage with a valid flag, so the block sits cleanly in a pipeline. Two optional extra layouts can be enabled by a parameter: upper-immediate and jump. The immediate can also be widened beyond 32 bits, and the extra upper bits then carry the sign.

Top module: `immgen_top`

## Requirements
- R1: With `in_sel` = 0 (load/arithmetic-immediate layout), `out_imm[11:0]` equals `in_instr[31:20]`. A word holding 000000001000 in bits [31:20] gives +8, and a word holding 111111001110 gives -50 (0xFFFFFFCE).
- R2: For select codes 0, 1 and 2, every bit of `out_imm` from bit 12 up to the top bit equals `in_instr[31]`.
- R3: With `in_sel` = 1 (store layout), `out_imm[11:5]` equals `in_instr[31:25]` and `out_imm[4:0]` equals `in_instr[11:7]`.
- R4: With `in_sel` = 2 (conditional-branch layout), the output is an even byte offset. Bit 12 comes from `in_instr[31]`, bit 11 from `in_instr[7]`, bits [10:5] from `in_instr[30:25]`, bits [4:1] from `in_instr[11:8]`, and bit 0 is zero. The offset range is -4096 (0xFFFFF000) to +4094 (0x00000FFE).
- R5: With `in_sel` = 3 (upper-immediate layout, enabled by default), `out_imm[31:12]` equals `in_instr[31:12]` and `out_imm[11:0]` is zero.
- R6: With `in_sel` = 4 (jump layout, enabled by default), bits [31:20] carry `in_instr[31]`. Bits [19:12] come from `in_instr[19:12]`, bit 11 from `in_instr[20]`, bits [10:1] from `in_instr[30:21]`, and bit 0 is zero.
- R7: Select codes 5, 6 and 7 produce an all-zero immediate.
- R8: `out_valid` is high exactly one cycle after `in_valid` was high, and `out_imm` shows the immediate of the word sampled on that edge. When `in_valid` is low, `out_imm` holds its value whatever `in_instr` and `in_sel` do.
- R9: While `rst_n` is low, `out_valid` and `out_imm` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word and select are valid this cycle |
| in_instr | input | 32 | Instruction word |
| in_sel | input | 3 | Layout select: 0 load/arith, 1 store, 2 branch, 3 upper, 4 jump |
| out_valid | output | 1 | Registered immediate is new this cycle |
| out_imm | output | IMM_W (32) | Registered sign-extended immediate |

## Verification
The hardest cases to reach from the ports are the extremes of the branch offset and the bits that move between layouts. Bit 11 takes a different instruction bit in every format, and an error there shows only when that source bit differs from the sign bit. The stimulus therefore includes hand-built branch words at -4096 and +4094 and the two documented load/arithmetic words. It then walks every select code over pseudo-random words in which bit 31, bit 20 and bit 7 vary on their own. Idle cycles with changing inputs are placed between transactions to show that the output holds.

// File: rtl/immgen_pkg.sv
package immgen_pkg;
   localparam int INSTR_W = 32;
   localparam int SEL_W   = 3;
   localparam int BASE_W  = 32;
   localparam int LO_W    = 11;

   typedef enum logic [SEL_W-1:0] {
      FMT_I = 3'd0,
      FMT_S = 3'd1,
      FMT_B = 3'd2,
      FMT_U = 3'd3,
      FMT_J = 3'd4
   } imm_fmt_e;
endpackage

// File: rtl/immgen_lo.sv
// Low immediate bits [10:0]: the only part where I and S differ is bits [4:0].
module immgen_lo
   import immgen_pkg::*;
(
   input  logic [SEL_W-1:0] fmt,
   input  logic             fmt_legal,
   input  logic [30:20]     f_hi,    // instruction bits 30..20
   input  logic [11:7]      f_lo,    // instruction bits 11..7
   output logic [LO_W-1:0]  lo_bits
);
   logic [4:0] low5;
   logic [5:0] mid6;

   always_comb begin
      low5 = '0;
      mid6 = '0;
      if (fmt_legal) begin
         unique case (fmt)
            FMT_I: begin low5 = f_hi[24:20];          mid6 = f_hi[30:25]; end
            FMT_S: begin low5 = f_lo[11:7];           mid6 = f_hi[30:25]; end
            FMT_B: begin low5 = {f_lo[11:8], 1'b0};   mid6 = f_hi[30:25]; end
            FMT_J: begin low5 = {f_hi[24:21], 1'b0};  mid6 = f_hi[30:25]; end
            default: begin low5 = '0;                 mid6 = '0;          end
         endcase
      end
   end

   assign lo_bits = {mid6, low5};
endmodule

// File: rtl/immgen_hi.sv
// High immediate bits [IMM_W-1:11]: bit 11, middle byte, top field, extension.
module immgen_hi
   import immgen_pkg::*;
#(
   parameter int IMM_W = 32
)(
   input  logic [SEL_W-1:0]  fmt,
   input  logic              fmt_legal,
   input  logic [31:12]      f_top,   // instruction bits 31..12
   input  logic              f_b7,    // instruction bit 7
   input  logic              f_b20,   // instruction bit 20
   output logic [IMM_W-1:11] hi_bits
);
   localparam int EXT_W = IMM_W - BASE_W;

   logic        sgn;
   logic        bit11;
   logic [7:0]  byte_mid;
   logic [11:0] top12;

   assign sgn = f_top[31];

   always_comb begin
      bit11    = 1'b0;
      byte_mid = '0;
      top12    = '0;
      if (fmt_legal) begin
         unique case (fmt)
            FMT_I, FMT_S: begin bit11 = sgn;   byte_mid = {8{sgn}};      top12 = {12{sgn}};    end
            FMT_B:        begin bit11 = f_b7;  byte_mid = {8{sgn}};      top12 = {12{sgn}};    end
            FMT_U:        begin bit11 = 1'b0;  byte_mid = f_top[19:12];  top12 = f_top[31:20]; end
            FMT_J:        begin bit11 = f_b20; byte_mid = f_top[19:12];  top12 = {12{sgn}};    end
            default:      begin bit11 = 1'b0;  byte_mid = '0;            top12 = '0;           end
         endcase
      end
   end

   generate
      if (EXT_W > 0) begin : g_wide
         logic [EXT_W-1:0] ext;
         assign ext     = {EXT_W{fmt_legal & sgn}};
         assign hi_bits = {ext, top12, byte_mid, bit11};
      end else begin : g_narrow
         assign hi_bits = {top12, byte_mid, bit11};
      end
   endgenerate
endmodule

// File: rtl/immgen_core.sv
module immgen_core
   import immgen_pkg::*;
#(
   parameter int IMM_W       = 32,
   parameter bit EXT_FORMATS = 1'b1
)(
   input  logic [31:7]      instr_f,
   input  logic [SEL_W-1:0] sel,
   output logic [IMM_W-1:0] imm
);
   logic             legal;
   logic [LO_W-1:0]  lo_part;
   logic [IMM_W-1:11] hi_part;

   generate
      if (EXT_FORMATS) begin : g_ext
         assign legal = (sel <= FMT_J);
      end else begin : g_base
         assign legal = (sel <= FMT_B);
      end
   endgenerate

   immgen_lo u_lo (
      .fmt       (sel),
      .fmt_legal (legal),
      .f_hi      (instr_f[30:20]),
      .f_lo      (instr_f[11:7]),
      .lo_bits   (lo_part)
   );

   immgen_hi #(.IMM_W(IMM_W)) u_hi (
      .fmt       (sel),
      .fmt_legal (legal),
      .f_top     (instr_f[31:12]),
      .f_b7      (instr_f[7]),
      .f_b20     (instr_f[20]),
      .hi_bits   (hi_part)
   );

   assign imm = {hi_part, lo_part};
endmodule

// File: rtl/immgen_top.sv
module immgen_top
   import immgen_pkg::*;
#(
   parameter int IMM_W       = 32,
   parameter bit EXT_FORMATS = 1'b1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [INSTR_W-1:0] in_instr,
   input  logic [SEL_W-1:0]   in_sel,
   output logic               out_valid,
   output logic [IMM_W-1:0]   out_imm
);
   localparam int SIGN_W = IMM_W - 12;

   generate
      if (IMM_W < BASE_W) begin : g_bad_width
         $error("immgen_top: IMM_W must be at least 32");
      end
   endgenerate

   logic [IMM_W-1:0] imm_c;
   logic             unused_opcode;

   assign unused_opcode = ^in_instr[6:0];

   immgen_core #(.IMM_W(IMM_W), .EXT_FORMATS(EXT_FORMATS)) u_core (
      .instr_f (in_instr[31:7]),
      .sel     (in_sel),
      .imm     (imm_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_imm   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_imm <= imm_c;
      end
   end

   assert_valid_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_valid_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_imm));
   assert_sign_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sel <= FMT_B) |=> out_imm[IMM_W-1:12] == {SIGN_W{$past(in_instr[31])}});
   assert_branch_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sel == FMT_B) |=> !out_imm[0]);
   assert_unused_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sel > FMT_J) |=> out_imm == '0);
   assert_upper_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sel == FMT_U && EXT_FORMATS) |=> out_imm[11:0] == 12'd0);
   assert_reset_R9: assert property (@(posedge clk)
      !rst_n |-> (!out_valid && out_imm == '0));
endmodule

// File: tb/sim_immgen_top.sv
`timescale 1ns/1ps
module sim_immgen_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_instr = '0;
   logic [2:0]  in_sel = '0;
   logic        out_valid;
   logic [31:0] out_imm;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic [31:0] lfsr = 32'h1ACE_B00C;

   always #2.5 clk = ~clk;

   immgen_top u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
      .in_sel(in_sel), .out_valid(out_valid), .out_imm(out_imm)
   );

   function automatic logic [31:0] ref_imm(input logic [31:0] w, input logic [2:0] s);
      logic [31:0] r;
      case (s)
         3'd0: r = 32'($signed(w) >>> 20);                                   // R1
         3'd1: r = {{20{w[31]}}, w[31:25], w[11:7]};                         // R3
         3'd2: r = {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};      // R4
         3'd3: r = {w[31:12], 12'h000};                                      // R5
         3'd4: r = {{11{w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};    // R6
         default: r = 32'h0;                                                 // R7
      endcase
      return r;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [31:0] w, input logic [2:0] s, input logic [31:0] exp, input string tag);
      @(negedge clk);
      in_valid = 1'b1; in_instr = w; in_sel = s;
      exp_q.push_back(exp); tag_q.push_back(tag);
   endtask

   task automatic idle(input logic [31:0] w, input logic [2:0] s);
      @(negedge clk);
      in_valid = 1'b0; in_instr = w; in_sel = s;
   endtask

   // monitor: samples 1 ns after each rising edge
   logic [31:0] last_imm = '0;
   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         if (out_valid) begin
            if (exp_q.size() == 0) begin
               check("R8 unexpected out_valid", 32'd1, 32'd0);
            end else begin
               logic [31:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(t, out_imm, e);
            end
         end else begin
            check("R8 hold while idle", out_imm, last_imm);
         end
         last_imm = out_imm;
      end
   end

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            check("R9 reset out_valid", {31'd0, out_valid}, 32'd0);
            check("R9 reset out_imm", out_imm, 32'd0);
            rst_n = 1'b1;
            send(32'h0081_2703, 3'd0, 32'h0000_0008, "R1 load +8");
            send(32'hFCE0_8793, 3'd0, 32'hFFFF_FFCE, "R1 addi -50");
            send(32'h8000_0063, 3'd2, 32'hFFFF_F000, "R4 branch -4096");
            send(32'h7E00_0FE3, 3'd2, 32'h0000_0FFE, "R4 branch +4094");
            send(32'hFE00_0FA3, 3'd1, 32'hFFFF_FFFF, "R3 store -1");
            send(32'hABCD_E037, 3'd3, 32'hABCD_E000, "R5 upper");
            send(32'h8010_006F, 3'd4, 32'hFFF0_0800, "R6 jump sign and bit11");
            send(32'hFFFF_FFFF, 3'd5, 32'h0, "R7 code 5");
            send(32'hFFFF_FFFF, 3'd7, 32'h0, "R7 code 7");
            idle(32'h1234_5678, 3'd1);
            idle(32'hFFFF_FFFF, 3'd3);
            for (int n = 0; n < 400; n++) begin
               lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
               begin
                  logic [2:0] s;
                  s = 3'(n % 8);
                  if (n % 7 == 3) idle(~lfsr, s);
                  else send(lfsr, s, ref_imm(lfsr, s),
                            (s == 0) ? "R1 random" : (s == 1) ? "R3 random" :
                            (s == 2) ? "R4/R2 random" : (s == 3) ? "R5 random" :
                            (s == 4) ? "R6 random" : "R7 random");
               end
            end
            idle('0, '0);
            repeat (4) @(negedge clk);
            check("R8 queue drained", 32'(exp_q.size()), 32'd0);
            done = 1'b1;
         end
         begin
            repeat (20000) @(posedge clk);
            if (!done) check("watchdog expired", 32'd1, 32'd0);
         end
      join_any
      disable fork;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule